// File: doc/BRIEF.md
# PCM Receive Word Deserializer with Robbed-LSB Marking

This block recovers one PCM code word per frame from a serial receive line. The bit clock, the receive frame sync and the serial data arrive as plain levels. A faster system clock oversamples them through a synchronizer. Data bits are taken on falling bit-clock edges, most significant bit first. Once the last bit of a frame has been taken, the block presents the whole word with a one-cycle valid strobe.

The sync pulse can take one of two timing forms, and the block classifies every frame by itself. A pulse seen high on exactly one falling edge is a short sync, and the data starts on the falling edge after it. A pulse that is still high on the second falling edge is a long sync, and the data starts on the same falling edge at which the pulse is first seen high. A long pulse that covers exactly two falling edges means the last bit carries signalling. For such a frame the block sets a robbed-LSB flag and clears the word's LSB, so that a later expander can substitute a half step.

Top module: `pcm_rx_deser`

## Requirements
- R1: While reset is asserted and after it is released, `word_o`, `word_valid_o` and `lsb_robbed_o` are all 0 until the first complete frame.
- R2: A short frame is a sync that is high at exactly one falling bit-clock edge, after being low at the previous falling edge. The next WORD_W falling edges supply the word, MSB first, and exactly one valid strobe follows. Falling edges without a sync produce no strobe.
- R3: A long frame is a sync that is seen high at the falling edge where it first rises and is still high at the next falling edge. Its word is taken from WORD_W falling edges starting with that first edge, MSB first.
- R4: The frame type is decided afresh for every frame, and the reset state already accepts either type. Short and long frames may alternate with no idle frame between them.
- R5: A long sync that is high at exactly two falling edges gives a word whose bits above the LSB are as received, with bit 0 forced to 0 and `lsb_robbed_o` set to 1.
- R6: Sync widths of one falling edge, or of three or more, give `lsb_robbed_o` = 0 and the received LSB unchanged.
- R7: `word_valid_o` is high for exactly one system-clock cycle per word. It rises SYNC_STAGES+1 system-clock edges after the falling bit-clock edge that carries the last bit.
- R8: If a new sync rises before the last bit of a word has been taken, the partial word is dropped without a strobe and capture restarts from the new sync.
- R9: `word_o` and `lsb_robbed_o` keep their values between strobes, whatever the data line does.
- R10: If a sync rises on the falling edge that carries the last bit of a word, that word still completes. The same edge also starts the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial inputs |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_bclk | input | 1 | Receive bit clock; data is taken on its falling edges |
| rx_fsync | input | 1 | Receive frame sync |
| rx_sdata | input | 1 | Serial PCM data, MSB first |
| word_o | output | WORD_W | Last completed word (LSB cleared when robbed) |
| word_valid_o | output | 1 | One-cycle strobe when a new word is presented |
| lsb_robbed_o | output | 1 | Set with the word when its LSB was used for signalling |

## Verification
The assertions assume that each level of the bit clock lasts at least two system-clock cycles after synchronization, so that two falling edges are never detected in adjacent cycles. They also assume that sync and data are steady around each falling bit-clock edge. The bench holds each bit-clock level for four system cycles and changes sync and data only together with the rising bit-clock edge. Within that constraint it sweeps every 8-bit code through short frames, long frames and two-edge robbed frames. It also applies aborted, back-to-back and idle sequences.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;

   typedef enum logic {
      FRM_SHORT = 1'b0,
      FRM_LONG  = 1'b1
   } frame_kind_t;

   // saturating 2-bit count of falling edges with the sync high
   function automatic logic [1:0] width_step(input logic [1:0] w);
      return (w == 2'd3) ? 2'd3 : w + 2'd1;
   endfunction

endpackage

// File: rtl/pcm_rx_sync.sv
module pcm_rx_sync #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   if (WIDTH < 1) begin : g_bad_width
      $error("pcm_rx_sync: WIDTH must be at least 1");
   end
   if (STAGES < 0) begin : g_bad_stages
      $error("pcm_rx_sync: STAGES must not be negative");
   end

   if (STAGES == 0) begin : g_bypass
      assign q_o = d_i;
   end else begin : g_chain
      logic [WIDTH-1:0] stg [STAGES];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
         end else begin
            stg[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
         end
      end

      assign q_o = stg[STAGES-1];
   end

endmodule

// File: rtl/pcm_rx_edge.sv
module pcm_rx_edge #(
   parameter bit CAPTURE_FALL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,
   output logic edge_o
);

   logic lvl_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_d <= CAPTURE_FALL ? 1'b0 : 1'b1;
      else        lvl_d <= lvl_i;
   end

   if (CAPTURE_FALL) begin : g_fall
      assign edge_o = lvl_d & ~lvl_i;
   end else begin : g_rise
      assign edge_o = ~lvl_d & lvl_i;
   end

   // R7: a capture edge needs the level to change, so never two in a row
   assert_edge_spacing_R7: assert property (@(posedge clk) disable iff (!rst_n)
      edge_o |=> !edge_o);

endmodule

// File: rtl/pcm_rx_shifter.sv
module pcm_rx_shifter #(
   parameter int WORD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_i,
   input  logic              bit_i,
   output logic [WORD_W-1:0] nxt_o
);

   logic [WORD_W-1:0] sh_q;

   assign nxt_o = {sh_q[WORD_W-2:0], bit_i};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sh_q <= '0;
      else if (shift_i) sh_q <= nxt_o;
   end

   assert_shift_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_i |=> $stable(sh_q));

endmodule

// File: rtl/pcm_rx_frame_ctrl.sv
module pcm_rx_frame_ctrl
   import pcm_rx_pkg::*;
#(
   parameter int WORD_W = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fall_i,
   input  logic fs_i,
   output logic done_o,
   output logic robbed_o
);

   localparam int CNT_W = $clog2(WORD_W + 2);
   localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(WORD_W);
   localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(WORD_W + 1);
   localparam logic [CNT_W-1:0] KIND_EDGE  = CNT_W'(2);

   if (WORD_W < 4) begin : g_bad_word
      $error("pcm_rx_frame_ctrl: WORD_W must be at least 4");
   end

   logic              prev_fs;
   logic              active;
   logic [CNT_W-1:0]  cnt;
   frame_kind_t       kind;
   logic [1:0]        width;
   logic              fs_run;

   logic              start;
   logic [CNT_W-1:0]  edge_no;
   logic [CNT_W-1:0]  last_edge;

   assign start     = fall_i & fs_i & ~prev_fs;
   assign edge_no   = cnt + CNT_W'(1);
   assign last_edge = (kind == FRM_LONG) ? LAST_LONG : LAST_SHORT;
   assign done_o    = fall_i & active & (edge_no == last_edge);
   assign robbed_o  = (width == 2'd2);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_fs <= 1'b0;
         active  <= 1'b0;
         cnt     <= '0;
         kind    <= FRM_SHORT;
         width   <= 2'd0;
         fs_run  <= 1'b0;
      end else if (fall_i) begin
         prev_fs <= fs_i;
         if (start) begin
            active <= 1'b1;
            cnt    <= CNT_W'(1);
            kind   <= FRM_SHORT;
            width  <= 2'd1;
            fs_run <= 1'b1;
         end else if (active) begin
            cnt <= edge_no;
            if (done_o) active <= 1'b0;
            if (edge_no == KIND_EDGE) kind <= fs_i ? FRM_LONG : FRM_SHORT;
            if (fs_run) begin
               if (fs_i) width  <= width_step(width);
               else      fs_run <= 1'b0;
            end
         end
      end
   end

   assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (cnt <= LAST_SHORT));

   assert_cnt_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !fall_i |=> $stable(cnt));

   assert_robbed_is_long_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && robbed_o) |-> (kind == FRM_LONG));

   assert_short_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && kind == FRM_SHORT) |-> (width == 2'd1));

endmodule

// File: rtl/pcm_rx_deser.sv
module pcm_rx_deser #(
   parameter int WORD_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_bclk,
   input  logic              rx_fsync,
   input  logic              rx_sdata,
   output logic [WORD_W-1:0] word_o,
   output logic              word_valid_o,
   output logic              lsb_robbed_o
);

   localparam int IN_W = 3;

   if (WORD_W < 4 || WORD_W > 16) begin : g_bad_word
      $error("pcm_rx_deser: WORD_W must lie in 4..16");
   end

   logic [IN_W-1:0]   pins_s;
   logic              bclk_s, fs_s, sd_s;
   logic              fall_e;
   logic              done;
   logic              rob;
   logic [WORD_W-1:0] nxt;

   pcm_rx_sync #(.WIDTH(IN_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({rx_bclk, rx_fsync, rx_sdata}),
      .q_o   (pins_s)
   );

   assign {bclk_s, fs_s, sd_s} = pins_s;

   pcm_rx_edge #(.CAPTURE_FALL(1'b1)) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_i  (bclk_s),
      .edge_o (fall_e)
   );

   pcm_rx_shifter #(.WORD_W(WORD_W)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .shift_i (fall_e),
      .bit_i   (sd_s),
      .nxt_o   (nxt)
   );

   pcm_rx_frame_ctrl #(.WORD_W(WORD_W)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .fall_i   (fall_e),
      .fs_i     (fs_s),
      .done_o   (done),
      .robbed_o (rob)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_o       <= '0;
         word_valid_o <= 1'b0;
         lsb_robbed_o <= 1'b0;
      end else begin
         word_valid_o <= done;
         if (done) begin
            word_o       <= {nxt[WORD_W-1:1], nxt[0] & ~rob};
            lsb_robbed_o <= rob;
         end
      end
   end

   assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid_o |=> !word_valid_o);

   assert_valid_after_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid_o |-> $past(fall_e));

   assert_robbed_lsb_R5: assert property (@(posedge clk) disable iff (!rst_n)
      lsb_robbed_o |-> !word_o[0]);

   assert_word_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (word_o != $past(word_o)) |-> word_valid_o);

endmodule

// File: tb/pcm_rx_deser_tb.sv
module pcm_rx_deser_tb;

   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         rx_bclk = 1'b0;
   logic         rx_fsync = 1'b0;
   logic         rx_sdata = 1'b0;
   logic [W-1:0] word_o;
   logic         word_valid_o;
   logic         lsb_robbed_o;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   int last_fall = 0;
   int mon_cnt = 0;
   logic [W-1:0] mon_word = '0;
   logic [W-1:0] mon_prev_word = '0;
   logic         mon_rob = 1'b0;
   logic         prev_valid = 1'b0;
   bit           done_flag = 1'b0;

   always #2 clk = ~clk;

   pcm_rx_deser #(.WORD_W(W), .SYNC_STAGES(2)) u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .rx_bclk      (rx_bclk),
      .rx_fsync     (rx_fsync),
      .rx_sdata     (rx_sdata),
      .word_o       (word_o),
      .word_valid_o (word_valid_o),
      .lsb_robbed_o (lsb_robbed_o)
   );

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // monitor: collects words, checks strobe width and latency (R7)
   always @(negedge clk) begin
      if (rst_n) begin
         if (word_valid_o) begin
            mon_cnt++;
            mon_prev_word = mon_word;
            mon_word = word_o;
            mon_rob = lsb_robbed_o;
            check(cyc - last_fall == 3, "R7 latency", cyc - last_fall, 3);
            check(!prev_valid, "R7 pulse width", 2, 1);
         end
         prev_valid = word_valid_o;
      end
   end

   task automatic bit_period(input bit fs, input bit d);
      @(negedge clk);
      rx_bclk = 1'b1; rx_fsync = fs; rx_sdata = d;
      repeat (3) @(negedge clk);
      @(negedge clk);
      rx_bclk = 1'b0; last_fall = cyc;
      repeat (3) @(negedge clk);
   endtask

   task automatic send_short(input logic [W-1:0] w);
      bit_period(1'b1, 1'b0);
      for (int i = 0; i < W; i++) bit_period(1'b0, w[W-1-i]);
   endtask

   task automatic send_long(input logic [W-1:0] w, input int width);
      for (int i = 0; i < W; i++) bit_period(i < width, w[W-1-i]);
   endtask

   task automatic expect_frame(input logic [W-1:0] w, input bit rob, input int base, input string req);
      logic [W-1:0] ew;
      ew = rob ? {w[W-1:1], 1'b0} : w;
      bit_period(1'b0, 1'b0);
      bit_period(1'b0, 1'b1);
      check(mon_cnt == base + 1, {req, " count"}, mon_cnt - base, 1);
      check(mon_word == ew, {req, " word"}, mon_word, ew);
      check(mon_rob == rob, {req, " robbed"}, mon_rob, rob);
   endtask

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

   initial begin
      int base;
      logic [W-1:0] w;
      repeat (6) @(negedge clk);
      // R1: reset state
      check(word_o == '0, "R1 word", word_o, 0);
      check(!word_valid_o, "R1 valid", word_valid_o, 0);
      check(!lsb_robbed_o, "R1 robbed", lsb_robbed_o, 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      check(word_o == '0 && !lsb_robbed_o, "R1 after release", word_o, 0);

      // R2: toggling data with no sync yields no word
      for (int i = 0; i < 12; i++) bit_period(1'b0, i[0]);
      check(mon_cnt == 0, "R2 no sync", mon_cnt, 0);

      // R2 R3 R4 R6: all codes, short and long frames alternating
      for (int i = 0; i < 256; i++) begin
         w = W'(i);
         base = mon_cnt;
         send_short(w);
         expect_frame(w, 1'b0, base, "R2 short");
         base = mon_cnt;
         send_long(w ^ 8'hA5, 3);
         expect_frame(w ^ 8'hA5, 1'b0, base, "R3 R4 R6 long");
      end

      // R5: two-edge sync robs the LSB, all codes
      for (int i = 0; i < 256; i++) begin
         w = W'(i);
         base = mon_cnt;
         send_long(w, 2);
         expect_frame(w, 1'b1, base, "R5 robbed");
      end

      // R6: sync high for the whole word, LSB kept
      for (int i = 0; i < 16; i++) begin
         w = W'(i * 17 + 1);
         base = mon_cnt;
         send_long(w, 8);
         expect_frame(w, 1'b0, base, "R6 full-width sync");
      end

      // R9: data toggling between frames leaves the word unchanged
      base = mon_cnt;
      send_long(8'h3C, 2);
      expect_frame(8'h3C, 1'b1, base, "R9 setup");
      for (int i = 0; i < 10; i++) bit_period(1'b0, ~i[0]);
      check(word_o == 8'h3C && lsb_robbed_o, "R9 hold", word_o, 8'h3C);
      check(mon_cnt == base + 1, "R9 no strobe", mon_cnt - base, 1);

      // R8: short sync, then a new short sync mid-word
      base = mon_cnt;
      bit_period(1'b1, 1'b0);
      for (int i = 0; i < 3; i++) bit_period(1'b0, 1'b1);
      send_short(8'h5A);
      expect_frame(8'h5A, 1'b0, base, "R8 abort short");

      // R8: short sync, then a long sync mid-word
      base = mon_cnt;
      bit_period(1'b1, 1'b0);
      for (int i = 0; i < 5; i++) bit_period(1'b0, 1'b0);
      send_long(8'hC3, 3);
      expect_frame(8'hC3, 1'b0, base, "R8 abort long");

      // R10: next sync coincides with the last bit of the current word
      base = mon_cnt;
      w = 8'h96;
      bit_period(1'b1, 1'b0);
      for (int i = 0; i < W - 1; i++) bit_period(1'b0, w[W-1-i]);
      bit_period(1'b1, w[0]);
      for (int i = 0; i < W; i++) bit_period(1'b0, 8'h2D >> (W - 1 - i));
      bit_period(1'b0, 1'b0);
      bit_period(1'b0, 1'b0);
      check(mon_cnt == base + 2, "R10 count", mon_cnt - base, 2);
      check(mon_prev_word == 8'h96, "R10 first word", mon_prev_word, 8'h96);
      check(mon_word == 8'h2D, "R10 second word", mon_word, 8'h2D);

      finish_run();
   end

endmodule